// File: doc/BRIEF.md
# Dual-Channel Interleaving Address Router

The router sits in front of two independent 64-bit memory channel controllers and accepts commands from two requesters, a CPU port and a GPU port. Each request carries a byte address and a write flag. The router decides which channel serves the address and computes the address inside that channel. It then forwards the command to that channel. When the two requesters target different channels, both commands go out in the same cycle.

In dual mode, 64-byte blocks alternate between the channels, but only across the span that both channels can back equally. The capacity left over on the larger channel is placed above that span and mapped linearly. In single mode, one chosen channel serves the whole address space on its own. An address beyond the configured capacity is answered at once with an error and is not forwarded. Channel sizes are configured separately, in units of 64 MiB.

Top module: `ilv_router`

## Requirements
- R1: After reset, no channel command is valid while no request is present. The first time both requesters contend for one channel, the CPU port wins.
- R2: Dual mode is `cfg_mode` 00 or 10. In dual mode, let m = min(`cfg_size0`, `cfg_size1`) and let the unit index be address bits [31:26]. If the unit index is below 2·m, address bit 6 selects the channel. The local address is then the byte address with bit 6 removed: bits [31:7] move down by one and bits [5:0] are kept.
- R3: In dual mode, a unit index from 2·m up to, but not including, `cfg_size0`+`cfg_size1` goes to the larger channel. This is channel 1 only when `cfg_size1` > `cfg_size0`. The local address is the byte address minus m·2^26.
- R4: Requests that map to different channels are forwarded in the same cycle. Each requester sees ready in the same cycle as its channel's ready.
- R5: In single mode, the selected channel receives every in-range request with local address equal to the byte address. Mode 01 selects channel 0 and mode 11 selects channel 1. The other channel's size has no effect.
- R6: An address at or above capacity is answered with ready and err high in its request cycle, and nothing is forwarded. Capacity is `cfg_size0`+`cfg_size1` units in dual mode, or the selected channel's size in single mode.
- R7: When both requesters target one channel in the same cycle, exactly one is forwarded and the other sees ready low.
- R8: Each channel keeps a round-robin pointer. After it accepts a command from one requester, the other requester has priority on that channel.
- R9: A forwarded command carries the requester's write flag. Its source tag is 0 for the CPU port and 1 for the GPU port.
- R10: While a channel holds ready low, its pending command stays valid and the requester's ready stays low. A requester's ready is never high without its valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | 00/10 dual, 01 single channel 0, 11 single channel 1 |
| cfg_size0 | input | SIZE_W | Channel 0 capacity in 64 MiB units |
| cfg_size1 | input | SIZE_W | Channel 1 capacity in 64 MiB units |
| cpu_valid | input | 1 | CPU request valid |
| cpu_ready | output | 1 | CPU request taken (forwarded or errored) |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_we | input | 1 | CPU write flag |
| cpu_err | output | 1 | CPU address out of range, with ready |
| gpu_valid | input | 1 | GPU request valid |
| gpu_ready | output | 1 | GPU request taken |
| gpu_addr | input | ADDR_W | GPU byte address |
| gpu_we | input | 1 | GPU write flag |
| gpu_err | output | 1 | GPU address out of range, with ready |
| ch0_valid | output | 1 | Command to channel 0 valid |
| ch0_ready | input | 1 | Channel 0 accepts |
| ch0_addr | output | ADDR_W-1 | Channel 0 local address |
| ch0_we | output | 1 | Channel 0 write flag |
| ch0_src | output | 1 | Channel 0 source tag |
| ch1_valid | output | 1 | Command to channel 1 valid |
| ch1_ready | input | 1 | Channel 1 accepts |
| ch1_addr | output | ADDR_W-1 | Channel 1 local address |
| ch1_we | output | 1 | Channel 1 write flag |
| ch1_src | output | 1 | Channel 1 source tag |

## Verification
The bench builds the router with its default widths: a 32-bit byte address, 64 MiB units and a 64-byte granule. With these widths, six unit-index bits cover the whole space, and channel sizes up to 31 units each reach the full 62-unit total. The bench steps through unequal sizes in both directions, equal sizes, a zero-sized channel, both single modes and the alternate dual encoding. Random addresses run up to two units past capacity, so that the interleaved span, the linear excess and the error edge are all crossed in every configuration.

// File: rtl/ilv_route_pkg.sv
package ilv_route_pkg;

    localparam int NREQ = 2;
    localparam int NCH  = 2;

    typedef enum logic [1:0] {
        MODE_DUAL     = 2'b00,
        MODE_SOLO0    = 2'b01,
        MODE_DUAL_ALT = 2'b10,
        MODE_SOLO1    = 2'b11
    } route_mode_e;

    // Round-robin state of one channel: which requester goes first on a tie.
    typedef struct packed {
        logic prio;
    } arb_state_t;

endpackage

// File: rtl/ilv_addr_map.sv
module ilv_addr_map
    import ilv_route_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int UNIT_BITS = 26,
    parameter int GRAN_BITS = 6,
    localparam int UW       = ADDR_W - UNIT_BITS,
    localparam int SIZE_W   = UW - 1,
    localparam int LW       = ADDR_W - 1
) (
    input  logic [1:0]        mode,
    input  logic [SIZE_W-1:0] size0,
    input  logic [SIZE_W-1:0] size1,
    input  logic [ADDR_W-1:0] addr,
    output logic              ch,
    output logic [LW-1:0]     laddr,
    output logic              err
);

    logic [UW-1:0]     unit_idx;
    logic [SIZE_W-1:0] common;
    logic [UW-1:0]     ilv_span;
    logic [UW-1:0]     total;
    logic [SIZE_W-1:0] lin_unit;

    always_comb begin
        unit_idx = addr[ADDR_W-1:UNIT_BITS];
        common   = (size0 < size1) ? size0 : size1;
        ilv_span = {common, 1'b0};
        total    = {1'b0, size0} + {1'b0, size1};
        lin_unit = unit_idx[SIZE_W-1:0] - common;
        ch       = 1'b0;
        laddr    = addr[LW-1:0];
        err      = 1'b0;
        case (route_mode_e'(mode))
            MODE_SOLO0: begin
                ch  = 1'b0;
                err = (unit_idx >= {1'b0, size0});
            end
            MODE_SOLO1: begin
                ch  = 1'b1;
                err = (unit_idx >= {1'b0, size1});
            end
            default: begin
                if (unit_idx < ilv_span) begin
                    ch    = addr[GRAN_BITS];
                    laddr = {addr[ADDR_W-1:GRAN_BITS+1], addr[GRAN_BITS-1:0]};
                end else if (unit_idx < total) begin
                    ch    = (size1 > size0);
                    laddr = {lin_unit, addr[UNIT_BITS-1:0]};
                end else begin
                    err = 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/ilv_chan_arb.sv
module ilv_chan_arb
    import ilv_route_pkg::*;
#(
    parameter int LW = 31
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREQ-1:0]           req,
    input  logic [NREQ-1:0][LW-1:0]   laddr,
    input  logic [NREQ-1:0]           we,
    input  logic                      ch_ready,
    output logic                      ch_valid,
    output logic [LW-1:0]             ch_addr,
    output logic                      ch_we,
    output logic                      ch_src,
    output logic [NREQ-1:0]           grant
);

    arb_state_t st_d, st_q;
    logic       win;

    always_comb begin
        st_d = st_q;
        if (req == {NREQ{1'b1}}) begin
            win = st_q.prio;
        end else begin
            win = req[1];
        end
        ch_valid   = |req;
        grant      = '0;
        if (ch_valid) begin
            grant[win] = 1'b1;
        end
        ch_addr    = laddr[win];
        ch_we      = we[win];
        ch_src     = win;
        if (ch_valid && ch_ready) begin
            st_d.prio = ~win;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ilv_router.sv
module ilv_router
    import ilv_route_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int UNIT_BITS = 26,
    parameter int GRAN_BITS = 6,
    localparam int SIZE_W   = ADDR_W - UNIT_BITS - 1,
    localparam int LW       = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic [SIZE_W-1:0] cfg_size0,
    input  logic [SIZE_W-1:0] cfg_size1,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    output logic              cpu_err,
    input  logic              gpu_valid,
    output logic              gpu_ready,
    input  logic [ADDR_W-1:0] gpu_addr,
    input  logic              gpu_we,
    output logic              gpu_err,
    output logic              ch0_valid,
    input  logic              ch0_ready,
    output logic [LW-1:0]     ch0_addr,
    output logic              ch0_we,
    output logic              ch0_src,
    output logic              ch1_valid,
    input  logic              ch1_ready,
    output logic [LW-1:0]     ch1_addr,
    output logic              ch1_we,
    output logic              ch1_src
);

    logic [NREQ-1:0]             rq_valid;
    logic [NREQ-1:0][ADDR_W-1:0] rq_addr;
    logic [NREQ-1:0]             rq_we;
    logic [NREQ-1:0]             rq_ready;
    logic [NREQ-1:0]             map_ch;
    logic [NREQ-1:0]             map_err;
    logic [NREQ-1:0][LW-1:0]     map_laddr;

    logic [NCH-1:0][NREQ-1:0]    route_req;
    logic [NCH-1:0][NREQ-1:0]    grant;
    logic [NCH-1:0]              ch_rdy;
    logic [NCH-1:0]              ch_vld;
    logic [NCH-1:0][LW-1:0]      ch_la;
    logic [NCH-1:0]              ch_wr;
    logic [NCH-1:0]              ch_id;

    assign rq_valid = {gpu_valid, cpu_valid};
    assign rq_addr  = {gpu_addr, cpu_addr};
    assign rq_we    = {gpu_we, cpu_we};
    assign ch_rdy   = {ch1_ready, ch0_ready};

    for (genvar r = 0; r < NREQ; r++) begin : g_req
        ilv_addr_map #(
            .ADDR_W    (ADDR_W),
            .UNIT_BITS (UNIT_BITS),
            .GRAN_BITS (GRAN_BITS)
        ) u_map (
            .mode  (cfg_mode),
            .size0 (cfg_size0),
            .size1 (cfg_size1),
            .addr  (rq_addr[r]),
            .ch    (map_ch[r]),
            .laddr (map_laddr[r]),
            .err   (map_err[r])
        );

        assign rq_ready[r] = rq_valid[r] &
                             (map_err[r] | (grant[map_ch[r]][r] & ch_rdy[map_ch[r]]));
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar r = 0; r < NREQ; r++) begin : g_sel
            assign route_req[c][r] = rq_valid[r] & ~map_err[r] & (map_ch[r] == c[0]);
        end

        ilv_chan_arb #(
            .LW (LW)
        ) u_arb (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (route_req[c]),
            .laddr    (map_laddr),
            .we       (rq_we),
            .ch_ready (ch_rdy[c]),
            .ch_valid (ch_vld[c]),
            .ch_addr  (ch_la[c]),
            .ch_we    (ch_wr[c]),
            .ch_src   (ch_id[c]),
            .grant    (grant[c])
        );
    end

    assign cpu_ready = rq_ready[0];
    assign gpu_ready = rq_ready[1];
    assign cpu_err   = rq_valid[0] & map_err[0];
    assign gpu_err   = rq_valid[1] & map_err[1];

    assign ch0_valid = ch_vld[0];
    assign ch0_addr  = ch_la[0];
    assign ch0_we    = ch_wr[0];
    assign ch0_src   = ch_id[0];
    assign ch1_valid = ch_vld[1];
    assign ch1_addr  = ch_la[1];
    assign ch1_we    = ch_wr[1];
    assign ch1_src   = ch_id[1];

endmodule

// File: rtl/ilv_router_chk.sv
module ilv_router_chk #(
    parameter int SIZE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SIZE_W-1:0] cfg_size0,
    input logic [SIZE_W-1:0] cfg_size1,
    input logic              cpu_valid,
    input logic              cpu_ready,
    input logic              cpu_err,
    input logic              gpu_valid,
    input logic              gpu_ready,
    input logic              gpu_err,
    input logic              ch0_valid,
    input logic              ch0_ready,
    input logic [SIZE_W-1:0] ch0_unit,
    input logic              ch0_src,
    input logic              ch1_valid,
    input logic              ch1_ready,
    input logic [SIZE_W-1:0] ch1_unit,
    input logic              ch1_src,
    input logic [3:0]        route_req
);

    // R4 / R7: every non-error acceptance matches exactly one channel handshake
    p_accept_balance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cpu_ready & ~cpu_err, gpu_ready & ~gpu_err}) ==
        $countones({ch0_valid & ch0_ready, ch1_valid & ch1_ready}));

    // R6: an errored request never appears on a channel
    p_err_not_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err |-> (cpu_valid && cpu_ready &&
                     !(ch0_valid && !ch0_src) && !(ch1_valid && !ch1_src)));

    // R3: a local address never exceeds the channel's own capacity
    p_local_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ch0_valid |-> ch0_unit < cfg_size0) and (ch1_valid |-> ch1_unit < cfg_size1));

    // R8: back-to-back contention on a channel alternates the winner
    p_rr_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(route_req[1:0] == 2'b11 && ch0_valid && ch0_ready) && route_req[1:0] == 2'b11)
        |-> ch0_src != $past(ch0_src));

    // R10: a stalled channel command stays presented while its requester waits
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_valid && !ch1_ready && cpu_valid && gpu_valid) |=> ch1_valid);

    // R10: ready only with valid
    p_ready_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready |-> cpu_valid) and (gpu_ready |-> gpu_valid));

endmodule

bind ilv_router ilv_router_chk #(
    .SIZE_W (SIZE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_size0 (cfg_size0),
    .cfg_size1 (cfg_size1),
    .cpu_valid (cpu_valid),
    .cpu_ready (cpu_ready),
    .cpu_err   (cpu_err),
    .gpu_valid (gpu_valid),
    .gpu_ready (gpu_ready),
    .gpu_err   (gpu_err),
    .ch0_valid (ch0_valid),
    .ch0_ready (ch0_ready),
    .ch0_unit  (ch0_addr[LW-1:UNIT_BITS]),
    .ch0_src   (ch0_src),
    .ch1_valid (ch1_valid),
    .ch1_ready (ch1_ready),
    .ch1_unit  (ch1_addr[LW-1:UNIT_BITS]),
    .ch1_src   (ch1_src),
    .route_req (route_req)
);

// File: tb/sim_ilv_router.sv
`timescale 1ns/1ps
module sim_ilv_router;

    localparam int  ADDR_W = 32;
    localparam int  UNIT_BITS = 26;
    localparam int  SIZE_W = 5;
    localparam int  LW = 31;
    localparam longint UNIT = 64'd1 << UNIT_BITS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [SIZE_W-1:0] cfg_size0 = 5'd4, cfg_size1 = 5'd2;
    logic cpu_valid = 0, cpu_we = 0, gpu_valid = 0, gpu_we = 0;
    logic [ADDR_W-1:0] cpu_addr = '0, gpu_addr = '0;
    logic cpu_ready, cpu_err, gpu_ready, gpu_err;
    logic ch0_valid, ch0_we, ch0_src, ch1_valid, ch1_we, ch1_src;
    logic ch0_ready = 1, ch1_ready = 1;
    logic [LW-1:0] ch0_addr, ch1_addr;

    int checks = 0, failures = 0;
    int prio [2] = '{0, 0};
    bit acc [2] = '{0, 0};
    bit gen_en = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ilv_router u0 (.*);

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic ref_map(input int mode, input int s0, input int s1, input longint a,
                           output int ch, output longint la, output bit err, output string tag);
        int c;
        c = (s0 < s1) ? s0 : s1;
        ch = 0; la = a; err = 0; tag = "R5";
        if (mode == 1) begin
            ch = 0; err = (a >= s0 * UNIT);
        end else if (mode == 3) begin
            ch = 1; err = (a >= s1 * UNIT);
        end else if (a < 2 * c * UNIT) begin
            ch = int'((a >> 6) & 1); la = ((a >> 7) << 6) | (a & 63); tag = "R2";
        end else if (a < (s0 + s1) * UNIT) begin
            ch = (s1 > s0) ? 1 : 0; la = a - c * UNIT; tag = "R3";
        end else begin
            err = 1;
        end
        if (err) tag = "R6";
    endtask

    task automatic compare();
        bit v [2], we_ [2], eerr [2], crdy [2], av [2], aw [2], asrc [2], ardy [2], aerr [2];
        longint a [2], ela [2], ala [2];
        int ech [2], n [2], w [2];
        string etag [2];
        v = '{cpu_valid, gpu_valid}; we_ = '{cpu_we, gpu_we};
        a = '{longint'(cpu_addr), longint'(gpu_addr)};
        crdy = '{ch0_ready, ch1_ready};
        av = '{ch0_valid, ch1_valid}; aw = '{ch0_we, ch1_we}; asrc = '{ch0_src, ch1_src};
        ala = '{longint'(ch0_addr), longint'(ch1_addr)};
        ardy = '{cpu_ready, gpu_ready}; aerr = '{cpu_err, gpu_err};
        for (int r = 0; r < 2; r++)
            ref_map(int'(cfg_mode), int'(cfg_size0), int'(cfg_size1), a[r],
                    ech[r], ela[r], eerr[r], etag[r]);
        for (int c = 0; c < 2; c++) begin
            n[c] = 0; w[c] = -1;
            for (int r = 0; r < 2; r++)
                if (v[r] && !eerr[r] && ech[r] == c) begin n[c]++; w[c] = r; end
            if (n[c] == 2) w[c] = prio[c];
            chk((n[c] == 2) ? "R7" : "R4", $sformatf("ch%0d_valid", c), longint'(av[c]), longint'(n[c] > 0));
            if (n[c] > 0) begin
                chk(etag[w[c]], $sformatf("ch%0d_addr", c), ala[c], ela[w[c]]);
                chk((n[c] == 2) ? "R8" : "R9", $sformatf("ch%0d_src", c), longint'(asrc[c]), longint'(w[c]));
                chk("R9", $sformatf("ch%0d_we", c), longint'(aw[c]), longint'(we_[w[c]]));
            end
        end
        for (int r = 0; r < 2; r++) begin
            bit er;
            string tg;
            if (!v[r]) begin er = 0; tg = "R10"; end
            else if (eerr[r]) begin er = 1; tg = "R6"; end
            else begin
                er = (w[ech[r]] == r) && crdy[ech[r]];
                if (w[ech[r]] != r) tg = "R7";
                else if (!crdy[ech[r]]) tg = "R10";
                else tg = "R4";
            end
            chk(tg, $sformatf("req%0d_ready", r), longint'(ardy[r]), longint'(er));
            chk("R6", $sformatf("req%0d_err", r), longint'(aerr[r]), longint'(v[r] && eerr[r]));
            acc[r] = v[r] && er;
        end
        for (int c = 0; c < 2; c++)
            if (n[c] > 0 && crdy[c]) prio[c] = 1 - w[c];
    endtask

    function automatic logic [ADDR_W-1:0] pick_addr();
        int span, u;
        span = int'(cfg_size0) + int'(cfg_size1) + 2;
        u = int'($urandom % span);
        if (u > 63) u = 63;
        return ADDR_W'((longint'(u) * UNIT) | longint'($urandom % 32'h0400_0000));
    endfunction

    task automatic drive();
        if (!cpu_valid || acc[0]) begin
            cpu_valid = gen_en && ($urandom % 4 != 0);
            cpu_addr = pick_addr(); cpu_we = 1'($urandom);
        end
        if (!gpu_valid || acc[1]) begin
            gpu_valid = gen_en && ($urandom % 4 != 0);
            gpu_addr = pick_addr(); gpu_we = 1'($urandom);
        end
        ch0_ready = !gen_en || ($urandom % 4 != 0);
        ch1_ready = !gen_en || ($urandom % 4 != 0);
    endtask

    task automatic run(input int cycles);
        repeat (cycles) begin
            @(posedge clk); #1;
            drive();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic phase(input logic [1:0] m, input int s0, input int s1, input int cycles);
        gen_en = 0;
        run(4);
        cfg_mode = m; cfg_size0 = SIZE_W'(s0); cfg_size1 = SIZE_W'(s1);
        gen_en = 1;
        run(cycles);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ch0_valid idle", longint'(ch0_valid), 0);
        chk("R1", "ch1_valid idle", longint'(ch1_valid), 0);
        chk("R1", "cpu_ready idle", longint'(cpu_ready), 0);
        // first contention: both target channel 0 (bit 6 clear, inside interleave)
        @(posedge clk); #1;
        cpu_valid = 1; cpu_addr = 32'h0000_0100; gpu_valid = 1; gpu_addr = 32'h0000_0200;
        @(negedge clk);
        chk("R1", "first contention src", longint'(ch0_src), 0);
        compare();
        phase(2'b00, 4, 2, 1500);
        phase(2'b00, 1, 3, 1500);
        phase(2'b00, 2, 2, 1500);
        phase(2'b01, 2, 5, 1500);
        phase(2'b11, 6, 3, 1500);
        phase(2'b00, 0, 2, 1500);
        phase(2'b10, 31, 31, 1500);
        gen_en = 0;
        run(4);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule